// File: doc/BRIEF.md
# Segmented Line Readout Timing Generator

This block produces the frame, line and pixel timing for an image sensor whose lines are read out as eight equal segments. It drives a frame-sync pulse, a line-sync pulse, a gated pixel clock, a 12-bit pixel word and a pixel-valid flag. Between two segments of a line the pixel clock stops for a fixed gap. Every duration is a parameter counted in system clock cycles, so the same RTL runs at full scale or at scaled-down values.

A two-bit binning select chooses one of three formats. Binning scales the number of lines in a frame down by 1, 2 or 4 and picks a wider line-sync pulse for the coarser formats. Frames either repeat on an internal period or start a fixed delay after a rising edge on the trigger input. The pixel words come from a built-in test pattern. The pattern carries the segment index and the pixel index, so a receiver can check the readout order.

Top module: `seg_readout_timer`

## Requirements
- R1: Every line carries NUM_SEG = 8 segments of SEG_PIX pixels, giving exactly 8*SEG_PIX pixel-clock pulses between two line-sync pulses. The pixel clock stays low while frame sync or line sync is high.
- R2: The pixel clock is high for PIX_HALF cycles and low for PIX_HALF cycles within a segment. Between the last pixel of a segment and the first pixel of the next, it stays low for PIX_HALF + GAP_CYC cycles.
- R3: The pixel word changes one cycle after the pixel clock rises and holds steady across the falling edge, where pix_valid_o is high. Its value is v = segment_index*512 + pixel_index, with the segment in v[11:9] and the pixel in v[8:0]. The bus is bit-reversed: pix_data_o[i] = v[11-i], so pix_data_o[0] carries the MSB.
- R4: pix_valid_o is low between segments and while line sync is high.
- R5: Binning select encoding: 00 gives LINES lines with line-sync width LSYNC1_CYC; 01 gives LINES/2 lines with LSYNC2_CYC; 10 and 11 give LINES/4 lines with LSYNC4_CYC.
- R6: Frame sync is high for FSYNC_CYC cycles. The first line sync rises FS2LS_CYC cycles after frame sync falls. Frame sync and line sync are never high together.
- R7: In internal mode (ext_sel_i = 0), the first frame starts right after reset and frame-sync rising edges are FRAME_CYC cycles apart. Trigger edges have no effect and do not set the overrun flag.
- R8: In external mode (ext_sel_i = 1), while the block is idle, a trigger rising edge starts a frame. A rising edge is trig_i high at a clock edge after being low at the one before. Frame sync rises on the (TRIG_DLY+1)th clock edge after the edge that first samples trig_i high.
- R9: In external mode, no frame starts without a trigger edge.
- R10: In external mode, a trigger edge that arrives while a frame is pending or being read out is ignored and sets overrun_o. overrun_o then stays high until reset.
- R11: The binning select and the trigger mode are sampled once, when the readout of a frame ends. A change made during a frame applies from the next frame on.
- R12: While reset is high, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bin_mode_i | input | 2 | Binning select (00, 01, 10/11) |
| ext_sel_i | input | 1 | 0 = internal frame period, 1 = external trigger |
| trig_i | input | 1 | External trigger, synchronous to clk |
| fsync_o | output | 1 | Frame sync pulse |
| lsync_o | output | 1 | Line sync pulse |
| pclk_o | output | 1 | Gated pixel clock |
| pix_data_o | output | 12 | Test-pattern pixel word, bit-reversed |
| pix_valid_o | output | 1 | Pixel word valid |
| overrun_o | output | 1 | Sticky flag for an ignored trigger |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the overrun detector and the pixel stream: a trigger pulse is driven while pixels are being read out. The bench then checks that overrun_o rises, that the pixel order, gaps and line count of that frame stay intact, and that no extra frame follows. The second pair is the configuration sampler and a running frame: the binning select is changed right after a frame sync rises. The line count and line-sync width of that frame must keep the old format, and the following frame must show the new one.

// File: rtl/srt_pkg.sv
package srt_pkg;
    localparam int DATA_W = 12;
    localparam int SEG_W  = 3;
    localparam int PIX_W  = 9;
    localparam int NUM_SEG = 1 << SEG_W;
    localparam int CNT_W  = 32;

    typedef enum logic [3:0] {
        ST_LATCH, ST_WAIT, ST_TDLY, ST_FSYNC, ST_FDLY,
        ST_HSYNC, ST_HDLY, ST_PIX, ST_GAP
    } seq_st_e;

    typedef struct packed {
        logic [1:0] bin;
        logic       ext;
    } frame_cfg_t;

    // pattern word: segment in the top bits, pixel below; bus is bit-reversed
    function automatic logic [DATA_W-1:0] tp_word(input logic [SEG_W-1:0] seg,
                                                  input logic [PIX_W-1:0] pix);
        logic [DATA_W-1:0] v;
        logic [DATA_W-1:0] r;
        v = {seg, pix};
        for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
        return r;
    endfunction
endpackage

// File: rtl/srt_trig_edge.sv
module srt_trig_edge (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic edge_o
);
    logic trig_d, trig_q;

    always_comb begin
        trig_d = trig_i;
        edge_o = trig_i & ~trig_q;
    end

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b1;
        else     trig_q <= trig_d;
    end
endmodule

// File: rtl/srt_seq.sv
module srt_seq
    import srt_pkg::*;
#(
    parameter int SEG_PIX    = 300,
    parameter int PIX_HALF   = 2,
    parameter int GAP_CYC    = 12,
    parameter int FSYNC_CYC  = 46662,
    parameter int FS2LS_CYC  = 85,
    parameter int LSYNC1_CYC = 2121,
    parameter int LSYNC2_CYC = 6666,
    parameter int LSYNC4_CYC = 9090,
    parameter int PRE_CYC    = 4,
    parameter int LINES      = 2400,
    parameter int TRIG_DLY   = 23634,
    parameter int FRAME_CYC  = 28480000,
    localparam int SUB_W     = $clog2(2 * PIX_HALF),
    localparam int LINE_W    = $clog2(LINES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bin_i,
    input  logic             ext_i,
    input  logic             trig_edge_i,
    output seq_st_e          st_o,
    output logic [SUB_W-1:0] sub_o,
    output logic [SEG_W-1:0] seg_o,
    output logic [PIX_W-1:0] pix_o,
    output logic             ovr_o
);
    localparam logic [CNT_W-1:0]  FRM_LAST  = CNT_W'(FRAME_CYC - 1);
    localparam logic [CNT_W-1:0]  TDLY_LAST = CNT_W'(TRIG_DLY - 1);
    localparam logic [CNT_W-1:0]  FS_LAST   = CNT_W'(FSYNC_CYC - 1);
    localparam logic [CNT_W-1:0]  FL_LAST   = CNT_W'(FS2LS_CYC - 1);
    localparam logic [CNT_W-1:0]  PRE_LAST  = CNT_W'(PRE_CYC - 1);
    localparam logic [CNT_W-1:0]  GAP_LAST  = CNT_W'(GAP_CYC - 1);
    localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(2 * PIX_HALF - 1);
    localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(SEG_PIX - 1);
    localparam logic [SEG_W-1:0]  SEG_LAST  = SEG_W'(NUM_SEG - 1);

    typedef struct packed {
        seq_st_e           st;
        frame_cfg_t        cfg;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  frm;
        logic [SUB_W-1:0]  sub;
        logic [PIX_W-1:0]  pix;
        logic [SEG_W-1:0]  seg;
        logic [LINE_W-1:0] line;
        logic              ovr;
    } seq_t;

    seq_t s_d, s_q;
    logic [LINE_W-1:0] line_last;
    logic [CNT_W-1:0]  ls_last;

    always_comb begin
        case (s_q.cfg.bin)
            2'b00:   begin line_last = LINE_W'(LINES - 1);     ls_last = CNT_W'(LSYNC1_CYC - 1); end
            2'b01:   begin line_last = LINE_W'(LINES / 2 - 1); ls_last = CNT_W'(LSYNC2_CYC - 1); end
            default: begin line_last = LINE_W'(LINES / 4 - 1); ls_last = CNT_W'(LSYNC4_CYC - 1); end
        endcase

        s_d = s_q;
        s_d.frm = (s_q.frm == FRM_LAST) ? s_q.frm : s_q.frm + CNT_W'(1);
        s_d.cnt = s_q.cnt + CNT_W'(1);
        if (trig_edge_i && s_q.cfg.ext && s_q.st != ST_WAIT) s_d.ovr = 1'b1;

        case (s_q.st)
            ST_LATCH: begin
                s_d.cfg = '{bin: bin_i, ext: ext_i};
                s_d.st  = ST_WAIT;
            end
            ST_WAIT: begin
                if (s_q.cfg.ext) begin
                    if (trig_edge_i) begin s_d.st = ST_TDLY; s_d.cnt = '0; end
                end else if (s_q.frm == FRM_LAST) begin
                    s_d.st = ST_FSYNC; s_d.cnt = '0; s_d.frm = '0;
                end
            end
            ST_TDLY: if (s_q.cnt == TDLY_LAST) begin
                s_d.st = ST_FSYNC; s_d.cnt = '0; s_d.frm = '0;
            end
            ST_FSYNC: if (s_q.cnt == FS_LAST) begin
                s_d.st = ST_FDLY; s_d.cnt = '0; s_d.line = '0;
            end
            ST_FDLY: if (s_q.cnt == FL_LAST) begin
                s_d.st = ST_HSYNC; s_d.cnt = '0;
            end
            ST_HSYNC: if (s_q.cnt == ls_last) begin
                s_d.st = ST_HDLY; s_d.cnt = '0;
            end
            ST_HDLY: if (s_q.cnt == PRE_LAST) begin
                s_d.st = ST_PIX; s_d.sub = '0; s_d.pix = '0; s_d.seg = '0;
            end
            ST_PIX: begin
                s_d.sub = s_q.sub + SUB_W'(1);
                if (s_q.sub == SUB_LAST) begin
                    s_d.sub = '0;
                    if (s_q.pix != PIX_LAST) begin
                        s_d.pix = s_q.pix + PIX_W'(1);
                    end else begin
                        s_d.pix = '0;
                        s_d.cnt = '0;
                        if (s_q.seg != SEG_LAST) begin
                            s_d.seg = s_q.seg + SEG_W'(1);
                            s_d.st  = ST_GAP;
                        end else if (s_q.line == line_last) begin
                            s_d.st = ST_LATCH;
                        end else begin
                            s_d.line = s_q.line + LINE_W'(1);
                            s_d.st   = ST_HSYNC;
                        end
                    end
                end
            end
            ST_GAP: if (s_q.cnt == GAP_LAST) begin
                s_d.st = ST_PIX; s_d.sub = '0;
            end
            default: s_d.st = ST_LATCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q      <= '0;
            s_q.st   <= ST_LATCH;
            s_q.frm  <= FRM_LAST;
        end else begin
            s_q <= s_d;
        end
    end

    assign st_o  = s_q.st;
    assign sub_o = s_q.sub;
    assign seg_o = s_q.seg;
    assign pix_o = s_q.pix;
    assign ovr_o = s_q.ovr;
endmodule

// File: rtl/srt_out.sv
module srt_out
    import srt_pkg::*;
#(
    parameter int PIX_HALF = 2,
    localparam int SUB_W   = $clog2(2 * PIX_HALF)
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_st_e           st_i,
    input  logic [SUB_W-1:0]  sub_i,
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [PIX_W-1:0]  pix_i,
    output logic              fsync_o,
    output logic              lsync_o,
    output logic              pclk_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    typedef struct packed {
        logic              fs;
        logic              ls;
        logic              pc;
        logic              vld;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d    = o_q;
        o_d.fs = (st_i == ST_FSYNC);
        o_d.ls = (st_i == ST_HSYNC);
        o_d.pc = (st_i == ST_PIX) && (sub_i < SUB_W'(PIX_HALF));
        if (st_i == ST_PIX) begin
            // word moves one cycle after the clock rise
            if (sub_i == SUB_W'(1)) begin
                o_d.vld  = 1'b1;
                o_d.data = tp_word(seg_i, pix_i);
            end
        end else begin
            o_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) o_q <= '0;
        else     o_q <= o_d;
    end

    assign fsync_o = o_q.fs;
    assign lsync_o = o_q.ls;
    assign pclk_o  = o_q.pc;
    assign data_o  = o_q.data;
    assign valid_o = o_q.vld;
endmodule

// File: rtl/seg_readout_timer.sv
module seg_readout_timer
    import srt_pkg::*;
#(
    parameter int SEG_PIX    = 300,
    parameter int PIX_HALF   = 2,
    parameter int GAP_CYC    = 12,
    parameter int FSYNC_CYC  = 46662,
    parameter int FS2LS_CYC  = 85,
    parameter int LSYNC1_CYC = 2121,
    parameter int LSYNC2_CYC = 6666,
    parameter int LSYNC4_CYC = 9090,
    parameter int PRE_CYC    = 4,
    parameter int LINES      = 2400,
    parameter int TRIG_DLY   = 23634,
    parameter int FRAME_CYC  = 28480000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  bin_mode_i,
    input  logic        ext_sel_i,
    input  logic        trig_i,
    output logic        fsync_o,
    output logic        lsync_o,
    output logic        pclk_o,
    output logic [11:0] pix_data_o,
    output logic        pix_valid_o,
    output logic        overrun_o
);
    localparam int SUB_W = $clog2(2 * PIX_HALF);

    logic             trig_edge;
    seq_st_e          st;
    logic [SUB_W-1:0] sub;
    logic [SEG_W-1:0] seg;
    logic [PIX_W-1:0] pix;

    srt_trig_edge u_edge (
        .clk(clk), .rst(rst), .trig_i(trig_i), .edge_o(trig_edge)
    );

    srt_seq #(
        .SEG_PIX(SEG_PIX), .PIX_HALF(PIX_HALF), .GAP_CYC(GAP_CYC),
        .FSYNC_CYC(FSYNC_CYC), .FS2LS_CYC(FS2LS_CYC),
        .LSYNC1_CYC(LSYNC1_CYC), .LSYNC2_CYC(LSYNC2_CYC), .LSYNC4_CYC(LSYNC4_CYC),
        .PRE_CYC(PRE_CYC), .LINES(LINES), .TRIG_DLY(TRIG_DLY), .FRAME_CYC(FRAME_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .bin_i(bin_mode_i), .ext_i(ext_sel_i),
        .trig_edge_i(trig_edge), .st_o(st), .sub_o(sub), .seg_o(seg),
        .pix_o(pix), .ovr_o(overrun_o)
    );

    srt_out #(.PIX_HALF(PIX_HALF)) u_out (
        .clk(clk), .rst(rst), .st_i(st), .sub_i(sub), .seg_i(seg), .pix_i(pix),
        .fsync_o(fsync_o), .lsync_o(lsync_o), .pclk_o(pclk_o),
        .data_o(pix_data_o), .valid_o(pix_valid_o)
    );
endmodule

// File: rtl/srt_checker.sv
module srt_checker (
    input logic        clk,
    input logic        rst,
    input logic        fsync_o,
    input logic        lsync_o,
    input logic        pclk_o,
    input logic [11:0] pix_data_o,
    input logic        pix_valid_o,
    input logic        overrun_o
);
    assert_sync_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        fsync_o |-> !lsync_o && !pclk_o);

    assert_no_pclk_in_lsync_R1: assert property (@(posedge clk) disable iff (rst)
        lsync_o |-> !pclk_o);

    assert_invalid_in_lsync_R4: assert property (@(posedge clk) disable iff (rst)
        lsync_o |-> !pix_valid_o);

    assert_data_held_at_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(pclk_o) |-> pix_valid_o && $stable(pix_data_o));

    assert_data_held_at_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(pclk_o) |-> $stable(pix_data_o));

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> overrun_o);
endmodule

bind seg_readout_timer srt_checker u_chk (
    .clk(clk), .rst(rst), .fsync_o(fsync_o), .lsync_o(lsync_o), .pclk_o(pclk_o),
    .pix_data_o(pix_data_o), .pix_valid_o(pix_valid_o), .overrun_o(overrun_o)
);

// File: tb/seg_readout_timer_bench.sv
`timescale 1ns/1ps
module seg_readout_timer_bench;
    localparam int N    = 4;
    localparam int H    = 2;
    localparam int GAP  = 6;
    localparam int FSW  = 10;
    localparam int FSL  = 3;
    localparam int LS1  = 5;
    localparam int LS2  = 8;
    localparam int LS4  = 12;
    localparam int PRE  = 2;
    localparam int LN   = 4;
    localparam int TDL  = 7;
    localparam int FRM  = 800;
    localparam int LINE_PIX = 8 * N;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bin_mode_i = 2'b00;
    logic        ext_sel_i = 1'b0;
    logic        trig_i = 1'b0;
    logic        fsync_o, lsync_o, pclk_o, pix_valid_o, overrun_o;
    logic [11:0] pix_data_o;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    seg_readout_timer #(
        .SEG_PIX(N), .PIX_HALF(H), .GAP_CYC(GAP), .FSYNC_CYC(FSW), .FS2LS_CYC(FSL),
        .LSYNC1_CYC(LS1), .LSYNC2_CYC(LS2), .LSYNC4_CYC(LS4), .PRE_CYC(PRE),
        .LINES(LN), .TRIG_DLY(TDL), .FRAME_CYC(FRM)
    ) u_seg_readout_timer (
        .clk(clk), .rst(rst), .bin_mode_i(bin_mode_i), .ext_sel_i(ext_sel_i),
        .trig_i(trig_i), .fsync_o(fsync_o), .lsync_o(lsync_o), .pclk_o(pclk_o),
        .pix_data_o(pix_data_o), .pix_valid_o(pix_valid_o), .overrun_o(overrun_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_word(input int k);
        logic [11:0] v;
        logic [11:0] r;
        v = 12'((k / N) * 512 + (k % N));
        for (int i = 0; i < 12; i++) r[i] = v[11-i];
        return r;
    endfunction

    // monitor state
    int cyc = 0;
    int fs_rises = 0, fs_t = 0, fs_period = 0, fs_hi = 0, fs_w = 0;
    int fsls_cnt = 0, fs_ls = 0;
    int lines_in_frame = 0, prev_lines = 0;
    int ls_hi = 0, ls_w = 0;
    int pix_in_line = 0, hi_run = 0, lo_run = 0;
    logic fs_p = 0, ls_p = 0, pc_p = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst) begin
            // frame sync
            if (fsync_o && !fs_p) begin
                fs_rises++;
                if (fs_rises > 1) fs_period = cyc - fs_t;
                fs_t = cyc;
                if (lines_in_frame > 0)
                    chk(pix_in_line == LINE_PIX, "R1 pixels per line", pix_in_line, LINE_PIX);
                pix_in_line = 0;
                prev_lines = lines_in_frame;
                lines_in_frame = 0;
                fs_hi = 0;
            end
            if (fsync_o) fs_hi++;
            if (!fsync_o && fs_p) begin fs_w = fs_hi; fsls_cnt = 0; end
            if (!fsync_o && !lsync_o && lines_in_frame == 0) fsls_cnt++;
            // line sync
            if (lsync_o && !ls_p) begin
                if (lines_in_frame == 0) fs_ls = fsls_cnt;
                else chk(pix_in_line == LINE_PIX, "R1 pixels per line", pix_in_line, LINE_PIX);
                chk(pix_valid_o == 1'b0, "R4 valid low at line sync", pix_valid_o, 0);
                pix_in_line = 0;
                lines_in_frame++;
                ls_hi = 0;
            end
            if (lsync_o) ls_hi++;
            if (!lsync_o && ls_p) ls_w = ls_hi;
            // pixel clock
            if (pclk_o && !pc_p) begin
                if (pix_in_line > 0) begin
                    if (pix_in_line % N == 0) begin
                        chk(lo_run == H + GAP, "R2 segment gap", lo_run, H + GAP);
                        chk(pix_valid_o == 1'b0, "R4 valid low in gap", pix_valid_o, 0);
                    end else begin
                        chk(lo_run == H, "R2 low time", lo_run, H);
                    end
                end
                pix_in_line++;
                hi_run = 1;
            end else if (!pclk_o && pc_p) begin
                chk(hi_run == H, "R2 high time", hi_run, H);
                chk(pix_valid_o == 1'b1, "R3 valid at fall", pix_valid_o, 1);
                chk(pix_data_o == exp_word(pix_in_line - 1), "R3 pattern word",
                    pix_data_o, exp_word(pix_in_line - 1));
                lo_run = 1;
            end else if (pclk_o) hi_run++;
            else lo_run++;
            fs_p = fsync_o; ls_p = lsync_o; pc_p = pclk_o;
        end
    end

    task automatic wait_rise(input int k);
        while (fs_rises < k) @(negedge clk);
    endtask

    task automatic frame_check(input string tag, input int lines, input int lsw);
        chk(prev_lines == lines, {tag, " lines per frame"}, prev_lines, lines);
        chk(ls_w == lsw, {tag, " line sync width"}, ls_w, lsw);
    endtask

    task automatic trig_pulse(input int width);
        @(negedge clk) trig_i = 1'b1;
        repeat (width) @(negedge clk);
        trig_i = 1'b0;
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        // R12 reset state
        chk(fsync_o == 0 && lsync_o == 0 && pclk_o == 0, "R12 syncs low in reset",
            {fsync_o, lsync_o, pclk_o}, 0);
        chk(pix_valid_o == 0 && pix_data_o == 0 && overrun_o == 0, "R12 data low in reset",
            {pix_valid_o, overrun_o, pix_data_o}, 0);
        rst = 1'b0;

        // R7 internal free run, mode 00
        wait_rise(1);
        trig_pulse(3);
        wait_rise(2);
        chk(fs_period == FRM, "R7 frame period", fs_period, FRM);
        chk(fs_w == FSW, "R6 frame sync width", fs_w, FSW);
        chk(fs_ls == FSL, "R6 fsync to lsync delay", fs_ls, FSL);
        chk(overrun_o == 0, "R7 trigger ignored internally", overrun_o, 0);
        frame_check("R5 1x1", LN, LS1);

        // R11 mid-frame change to 01
        bin_mode_i = 2'b01;
        wait_rise(3);
        frame_check("R11 old mode kept", LN, LS1);
        wait_rise(4);
        frame_check("R5 2x2", LN / 2, LS2);
        chk(fs_period == FRM, "R7 frame period", fs_period, FRM);
        bin_mode_i = 2'b10;
        wait_rise(5);
        frame_check("R11 old mode kept", LN / 2, LS2);
        bin_mode_i = 2'b11;
        wait_rise(6);
        frame_check("R5 4x4 code 10", LN / 4, LS4);
        wait_rise(7);
        frame_check("R5 4x4 code 11", LN / 4, LS4);

        // R9 external mode, no trigger
        ext_sel_i = 1'b1;
        bin_mode_i = 2'b00;
        repeat (2 * FRM) @(negedge clk);
        chk(fs_rises == 7, "R9 no frame without trigger", fs_rises, 7);

        // R8 trigger delay
        @(negedge clk) trig_i = 1'b1;
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!fsync_o && n < 100);
        chk(n == TDL + 2, "R8 trigger to frame sync", n, TDL + 2);
        chk(overrun_o == 0, "R10 no overrun on idle trigger", overrun_o, 0);
        repeat (100) @(negedge clk);
        trig_i = 1'b0;

        // R10 trigger during readout
        repeat (200) @(negedge clk);
        trig_pulse(1);
        repeat (2) @(negedge clk);
        chk(overrun_o == 1, "R10 overrun set", overrun_o, 1);
        repeat (2 * FRM) @(negedge clk);
        chk(fs_rises == 8, "R10 busy trigger ignored", fs_rises, 8);
        trig_pulse(50);
        wait_rise(9);
        frame_check("R10 frame intact", LN, LS1);
        chk(overrun_o == 1, "R10 overrun sticky", overrun_o, 1);

        // R12 reset again
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(overrun_o == 0 && fsync_o == 0 && pix_valid_o == 0, "R12 reset clears",
            {overrun_o, fsync_o, pix_valid_o}, 0);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule